// File: doc/BRIEF.md
# Linear Systolic FIR Convolver

This block computes a one-dimensional finite-impulse-response convolution on a chain of identical cells. Signed input samples enter the first cell and move one cell further down the chain for every accepted sample. Each cell holds a small bank of signed coefficients and multiplies the sample in front of it by the coefficient picked by the active bank. It adds that product to the partial sum handed over by its upstream neighbour. Every cell registers the product and the sum in separate stages, so one sample's multiply overlaps the previous sample's add. The last cell's partial sum is the result. Once the chain has filled, one finished result leaves for each accepted sample.

The whole array moves only on cycles with a valid input sample, so gaps in the input stream pause it without losing state. A bank-select input travels with each sample, which lets a host swap between several coefficient sets without reloading them, as an adaptive filter needs. Coefficients are written through a separate load port while no sample is being offered.

Top module: `sysconv_array`

## Requirements
- R1: While reset is held and just after it is released, `out_valid` is 0 and `out_data` is 0. Reset also clears every coefficient to 0.
- R2: Number the accepted samples x(0), x(1), ... Result number i equals the sum over tap j = 0..TAPS-1 of w[j]·x(i+j). Tap 0 multiplies the oldest sample. Samples, coefficients and results are two's-complement signed.
- R3: Result i is presented with `out_valid` high in the cycle after the clock edge that accepts sample x(i+2·TAPS-1). It is valid for exactly that one cycle.
- R4: The first 2·TAPS-1 accepted samples after reset produce no valid output.
- R5: In a cycle with `in_valid` low, `out_valid` is low on the following cycle. Idle gaps of any length between samples leave all later results unchanged.
- R6: Results are ACC_W = 2·DATA_W + ceil(log2(TAPS)) bits wide and never overflow, including when all samples and all coefficients are the most negative value.
- R7: `in_sel` is taken with each accepted sample and chooses the coefficient bank for every cell together. Once the same bank has been selected for 2·TAPS consecutive samples, each result is computed wholly with that bank's coefficients.
- R8: A load into one bank leaves the results computed with any other bank unchanged, even while that other bank's samples are still in the chain.
- R9: A load is performed only in a cycle where `wl_en` is high and `in_valid` is low. `wl_tap` names the logical tap j of R2 and `wl_bank` names the bank. A load attempted in a cycle with `in_valid` high is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is offered this cycle |
| in_data | input | DATA_W | Signed input sample |
| in_sel | input | BANK_W | Coefficient bank taken with the sample |
| wl_en | input | 1 | Coefficient load request |
| wl_tap | input | TAP_W | Logical tap index to load |
| wl_bank | input | BANK_W | Bank to load |
| wl_data | input | DATA_W | Signed coefficient value |
| out_valid | output | 1 | A finished result is presented |
| out_data | output | ACC_W | Signed convolution result |

## Verification
A rising ramp under asymmetric coefficients shows that the taps line up with the correct samples: reversing the taps would give different sums. The same ramp with idle gaps between samples shows whether pauses are transparent, and the exact valid cycle shows whether the output appears too early or too late. A pseudo-random signed sequence under a second bank, with the bank switched mid-stream, checks that all cells move to the new bank together. Runs of the most negative value check the accumulation width. Loads attempted during streaming, and a load into an unused bank while another bank's samples are still in the chain, show whether a write leaks into the wrong time or the wrong bank.

// File: rtl/sysconv_pkg.sv
package sysconv_pkg;

    // Width of the accumulated result for a given sample width and tap count.
    function automatic int acc_width(input int data_w, input int taps);
        return 2 * data_w + ((taps > 1) ? $clog2(taps) : 0);
    endfunction

    // Width of an index that must hold at least one bit.
    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/sysconv_ctrl.sv
module sysconv_ctrl #(
    parameter int TAPS   = 3,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [BANK_W-1:0] sel_in,
    output logic [BANK_W-1:0] bank_q,
    output logic              out_valid
);
    localparam int FILL_MAX = 2 * TAPS - 1;
    localparam int FILL_W   = $clog2(2 * TAPS);

    typedef struct packed {
        logic [FILL_W-1:0] fill;
        logic [BANK_W-1:0] bank;
        logic              ovalid;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.ovalid = 1'b0;
        if (step) begin
            st_d.bank   = sel_in;
            st_d.ovalid = (st_q.fill == FILL_W'(FILL_MAX));
            if (st_q.fill != FILL_W'(FILL_MAX)) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_q    = st_q.bank;
    assign out_valid = st_q.ovalid;

    // R4: while the chain is still filling, an accepted sample yields no result
    a_r4_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q.fill != FILL_W'(FILL_MAX)) |=> !out_valid);

    // R5: no sample, no result on the next cycle
    a_r5_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> !out_valid);

    // R7: the active bank changes only with an accepted sample
    a_r7_bank_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(bank_q));

    // R3: a result is only ever presented once the chain is full
    a_r3_valid_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (st_q.fill == FILL_W'(FILL_MAX)));

endmodule

// File: rtl/sysconv_cell.sv
module sysconv_cell #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 18,
    parameter int BANKS  = 4,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [DATA_W-1:0] x_in,
    input  logic [ACC_W-1:0]  sum_in,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] x_out,
    output logic [ACC_W-1:0]  sum_out
);
    localparam int PROD_W = 2 * DATA_W;

    typedef struct packed {
        logic [BANKS-1:0][DATA_W-1:0] w;
        logic [DATA_W-1:0]            xa;
        logic [DATA_W-1:0]            xb;
        logic [PROD_W-1:0]            prod;
        logic [ACC_W-1:0]             sum;
    } cell_t;

    cell_t st_d, st_q;

    logic signed [PROD_W-1:0] mul_x_d, mul_w_d, mul_p_d;
    logic signed [ACC_W-1:0]  prod_ext_d, sum_new_d;

    always_comb begin
        mul_x_d    = PROD_W'($signed(x_in));
        mul_w_d    = PROD_W'($signed(st_q.w[bank_sel]));
        mul_p_d    = mul_x_d * mul_w_d;
        prod_ext_d = ACC_W'($signed(st_q.prod));
        sum_new_d  = $signed(sum_in) + prod_ext_d;

        st_d = st_q;
        if (wr_en) begin
            st_d.w[wr_bank] = wr_data;
        end
        if (step) begin
            st_d.xa   = x_in;
            st_d.xb   = st_q.xa;
            st_d.prod = mul_p_d;
            st_d.sum  = sum_new_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign x_out   = st_q.xb;
    assign sum_out = st_q.sum;

    // R5: pipeline contents hold across cycles without a sample
    a_r5_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(st_q.sum) && $stable(st_q.xb) && $stable(st_q.prod)));

    // R9: coefficients never change on a cycle that accepts a sample
    a_r9_no_load_in_stream: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(st_q.w));

endmodule

// File: rtl/sysconv_array.sv
module sysconv_array
    import sysconv_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TAPS   = 3,
    parameter int BANKS  = 4,
    parameter int ACC_W  = acc_width(DATA_W, TAPS),
    parameter int BANK_W = idx_width(BANKS),
    parameter int TAP_W  = idx_width(TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [BANK_W-1:0] in_sel,
    input  logic              wl_en,
    input  logic [TAP_W-1:0]  wl_tap,
    input  logic [BANK_W-1:0] wl_bank,
    input  logic [DATA_W-1:0] wl_data,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_data
);
    logic [BANK_W-1:0] bank_q;
    logic              load_ok;
    logic [DATA_W-1:0] x_chain   [0:TAPS];
    logic [ACC_W-1:0]  sum_chain [0:TAPS];
    logic [TAPS-1:0]   cell_wr;

    assign load_ok      = wl_en && !in_valid;
    assign x_chain[0]   = in_data;
    assign sum_chain[0] = '0;

    sysconv_ctrl #(
        .TAPS   (TAPS),
        .BANK_W (BANK_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (in_valid),
        .sel_in    (in_sel),
        .bank_q    (bank_q),
        .out_valid (out_valid)
    );

    // Cell k holds logical tap TAPS-1-k: the first cell meets the newest sample.
    for (genvar k = 0; k < TAPS; k++) begin : g_cell
        assign cell_wr[k] = load_ok && (wl_tap == TAP_W'(TAPS - 1 - k));

        sysconv_cell #(
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W),
            .BANKS  (BANKS),
            .BANK_W (BANK_W)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (in_valid),
            .bank_sel (bank_q),
            .x_in     (x_chain[k]),
            .sum_in   (sum_chain[k]),
            .wr_en    (cell_wr[k]),
            .wr_bank  (wl_bank),
            .wr_data  (wl_data),
            .x_out    (x_chain[k+1]),
            .sum_out  (sum_chain[k+1])
        );
    end

    assign out_data = sum_chain[TAPS];

    // R5: the sample leaving the chain only moves with an accepted sample
    a_r5_tail_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(x_chain[TAPS]));

    // R5: the presented result holds while the stream pauses
    a_r5_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    // R9: at most one cell is written per cycle
    a_r9_single_cell_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cell_wr));

endmodule

// File: tb/tb_sysconv_array.sv
module tb_sysconv_array;
    localparam int DW    = 8;
    localparam int K     = 3;
    localparam int NB    = 4;
    localparam int ACC   = 2 * DW + 2;
    localparam int BW    = 2;
    localparam int TW    = 2;
    localparam int LAT   = 2 * K - 1;
    localparam int HMAX  = 512;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DW-1:0]     in_data = '0;
    logic [BW-1:0]     in_sel = '0;
    logic              wl_en = 1'b0;
    logic [TW-1:0]     wl_tap = '0;
    logic [BW-1:0]     wl_bank = '0;
    logic [DW-1:0]     wl_data = '0;
    logic              out_valid;
    logic [ACC-1:0]    out_data;

    sysconv_array #(.DATA_W(DW), .TAPS(K), .BANKS(NB)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sel    (in_sel),
        .wl_en     (wl_en),
        .wl_tap    (wl_tap),
        .wl_bank   (wl_bank),
        .wl_data   (wl_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    hx [0:HMAX-1];
    int    hs [0:HMAX-1];
    int    he [0:HMAX-1];
    int    wm [0:NB-1][0:K-1];
    int    bep [0:NB-1];
    int    npulse = 0;
    int    expq [$];
    bit    careq [$];
    string reqq [$];
    bit    expv = 1'b0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    string tag_now = "R2";
    string vtag = "R4";

    function automatic int s8(input int v);
        int m;
        m = ((v % 256) + 256) % 256;
        return (m >= 128) ? m - 256 : m;
    endfunction

    // Monitor: compares the valid flag every cycle and pops results.
    always @(negedge clk) begin
        if (mon_on && !done) begin
            checks++;
            if (out_valid !== expv) begin
                errors++;
                $display("FAIL %s out_valid got %0b exp %0b (sample count %0d)",
                         vtag, out_valid, expv, npulse);
            end else if (out_valid) begin
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R3 result got %0d exp none", $signed(out_data));
                end else begin
                    int    e;
                    bit    c;
                    string r;
                    e = expq.pop_front();
                    c = careq.pop_front();
                    r = reqq.pop_front();
                    if (c) begin
                        int got;
                        got = $signed(out_data);
                        checks++;
                        if (got != e) begin
                            errors++;
                            $display("FAIL %s result got %0d exp %0d", r, got, e);
                        end
                    end
                end
            end
        end
    end

    task automatic send(input int x, input int sel, input bit try_wr);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = DW'(s8(x));
        in_sel   = BW'(sel);
        wl_en    = try_wr;
        wl_tap   = TW'(1);
        wl_bank  = BW'(sel);
        wl_data  = DW'(99);
        @(posedge clk);
        #1;
        hx[npulse] = s8(x);
        hs[npulse] = sel;
        he[npulse] = bep[sel];
        if (npulse >= LAT) begin
            int i;
            bit c;
            int y;
            i = npulse - LAT;
            c = 1'b1;
            for (int p = i; p <= npulse; p++) begin
                if (hs[p] != sel || he[p] != bep[sel]) c = 1'b0;
            end
            y = 0;
            for (int j = 0; j < K; j++) y += wm[sel][j] * hx[i + j];
            expq.push_back(y);
            careq.push_back(c);
            reqq.push_back(tag_now);
            expv = 1'b1;
            vtag = "R3";
        end else begin
            expv = 1'b0;
            vtag = "R4";
        end
        npulse++;
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            wl_en    = 1'b0;
            @(posedge clk);
            #1;
            expv = 1'b0;
            vtag = "R5";
        end
    endtask

    task automatic load(input int tap, input int bank, input int val);
        @(negedge clk);
        in_valid = 1'b0;
        wl_en    = 1'b1;
        wl_tap   = TW'(tap);
        wl_bank  = BW'(bank);
        wl_data  = DW'(s8(val));
        @(posedge clk);
        #1;
        expv = 1'b0;
        vtag = "R5";
        wm[bank][tap] = s8(val);
        bep[bank]++;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            bep[b] = 0;
            for (int j = 0; j < K; j++) wm[b][j] = 0;
        end

        // R1: reset state, during and after reset
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R1 in reset got v=%0b d=%0d exp v=0 d=0", out_valid, out_data);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R1 after reset got v=%0b d=%0d exp v=0 d=0", out_valid, out_data);
        end
        mon_on = 1'b1;

        // R2: asymmetric taps on a ramp; R4 covered by the first samples
        load(0, 0, 1);
        load(1, 0, 2);
        load(2, 0, 3);
        load(0, 1, -5);
        load(1, 1, 7);
        load(2, 1, -2);
        tag_now = "R2";
        for (int n = 1; n <= 12; n++) send(n, 0, 1'b0);

        // R5: idle gaps between samples must not change results
        tag_now = "R5";
        for (int n = 13; n <= 22; n++) begin
            send(n * 3 - 40, 0, 1'b0);
            idle(n % 4);
        end

        // R7: switch to bank 1 with a pseudo-random signed stream
        tag_now = "R7";
        for (int n = 0; n < 16; n++) send((n * 73 + 29) ^ (n * 5), 1, 1'b0);
        for (int n = 0; n < 8; n++) send(n * 37 - 100, 0, 1'b0);

        // R6: most negative coefficients and samples
        idle(2);
        load(0, 2, -128);
        load(1, 2, -128);
        load(2, 2, -128);
        tag_now = "R6";
        for (int n = 0; n < 8; n++) send(-128, 2, 1'b0);
        for (int n = 0; n < 8; n++) send(127, 2, 1'b0);
        for (int n = 0; n < 8; n++) send((n % 2 == 0) ? -128 : 127, 2, 1'b0);

        // R9: loads attempted while streaming are discarded
        tag_now = "R9";
        for (int n = 0; n < 14; n++) send(n * 11 - 60, 0, 1'b1);

        // R8: load another bank while bank 0 samples are in flight
        idle(1);
        load(0, 3, 55);
        load(2, 3, -77);
        tag_now = "R8";
        for (int n = 0; n < 10; n++) send(n * 19 - 90, 0, 1'b0);

        idle(3);
        done = 1'b1;
        checks++;
        if (expq.size() != (npulse - LAT)) begin
            if (expq.size() != 0) begin
                errors++;
                $display("FAIL R3 pending results got %0d exp 0", expq.size());
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule